// File: doc/BRIEF.md
# DMA Destination Address Generator

This block keeps the destination address for a single DMA channel. Each data beat can move the working address one unit up or down, or leave it where it is. At a boundary chosen in configuration (burst end, block end or end of transaction) the address returns to its programmed start value. The channel's data mover supplies the busy flag and the boundary strobes, and reads back the address it should write to next.

A four-bit configuration field sets the direction and the reload point. That field is frozen while the channel is busy. The block also stores an 8-bit trigger-select code. A code of zero means no trigger source is enabled. Any nonzero code is a peripheral's base code plus the offset of the trigger within that peripheral, and the block reports that triggering is enabled.

Top module: `dma_dst_addr_gen`

## Requirements
- R1: After reset, `addr` is 0, `cfg_rd` is 0, `trig_sel` is 0, `trig_enabled` is 0 and `reload_flag` is 0.
- R2: While busy, and not in the first busy cycle, a cycle with `beat_end` high and no reload moves the address. With direction code 00 (cfg bits 1:0) it stays put, with 01 it goes up by one, and with 10 it goes down by one. Steps wrap modulo 2^AW.
- R3: Direction code 11 is reserved and behaves exactly like 00. The address never moves under it.
- R4: Reload code (cfg bits 3:2) 00 never reloads. Code 01 reloads on `block_end`, code 10 on `burst_end` and code 11 on `txn_end`. A reload sets `addr` to `start_addr` on the next clock edge.
- R5: If a selected reload boundary and `beat_end` fall in the same cycle, the reload wins and `addr` becomes `start_addr`.
- R6: A boundary strobe that the reload code does not select has no effect on the address. Without `beat_end` the address holds.
- R7: The configuration byte is read on `cfg_rd` with reload in bits 3:2, direction in bits 1:0 and zeros in bits 7:4. A `cfg_we` write takes bits 3:0 of `cfg_wdata` only when `busy` is low. A write while busy is ignored and the old value is kept.
- R8: In the first cycle that `busy` is high after being low, `addr` is loaded with `start_addr`. Step and reload strobes in that cycle are ignored.
- R9: While `busy` is low, `addr` holds its value and all strobes are ignored.
- R10: `trig_we` writes `trig_wdata` into `trig_sel` whether or not the channel is busy. `trig_enabled` is high exactly when `trig_sel` is nonzero.
- R11: `reload_flag` is high for one cycle, in the cycle right after a reload of R4 is sampled, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data (reload 3:2, direction 1:0) |
| trig_we | input | 1 | Trigger-select write strobe |
| trig_wdata | input | 8 | Trigger-select write data |
| busy | input | 1 | Channel busy flag |
| start_addr | input | AW | Programmed start address |
| beat_end | input | 1 | End of one data beat |
| burst_end | input | 1 | End of a burst |
| block_end | input | 1 | End of a block |
| txn_end | input | 1 | End of the whole transaction |
| addr | output | AW | Current destination address |
| reload_flag | output | 1 | Reload performed on the previous edge |
| cfg_rd | output | 8 | Configuration byte readback |
| trig_sel | output | 8 | Stored trigger-select code |
| trig_enabled | output | 1 | Trigger-select code is nonzero |

## Verification
The bench sweeps all sixteen direction and reload pairs on a 4-bit address. Wraps are therefore frequent, and it checks that increment and decrement roll over rather than saturate. Random strobes produce cycles where a reload and a beat coincide; a design that let the step win would end one unit off the start value. Strobes for unselected boundaries are also mixed in; a design that decoded the reload field loosely would jump back at the wrong level. Configuration writes arrive while busy and must not change the readback. Each rise of busy is checked for a fresh start load, so a design that stepped in that first cycle would be caught.

// File: rtl/dda_pkg.sv
package dda_pkg;
  typedef enum logic [1:0] {DIR_FIXED = 2'b00, DIR_INC = 2'b01, DIR_DEC = 2'b10, DIR_RSVD = 2'b11} dir_e;
  typedef enum logic [1:0] {RLD_NONE = 2'b00, RLD_BLOCK = 2'b01, RLD_BURST = 2'b10, RLD_TXN = 2'b11} rld_e;

  localparam int CFG_W = 8;

  // true when the selected reload level sees its strobe
  function automatic logic rld_match(rld_e mode, logic burst, logic block, logic txn);
    case (mode)
      RLD_BLOCK: return block;
      RLD_BURST: return burst;
      RLD_TXN:   return txn;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dda_cfg_reg.sv
module dda_cfg_reg
  import dda_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             trig_we,
  input  logic [CFG_W-1:0] trig_wdata,
  output dir_e             dir,
  output rld_e             rld,
  output logic [CFG_W-1:0] cfg_rd,
  output logic [CFG_W-1:0] trig_sel,
  output logic             trig_enabled
);
  logic [3:0] cfg_q;
  logic       cfg_take;

  assign cfg_take = cfg_we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      trig_sel <= '0;
    end else begin
      if (cfg_take) cfg_q <= cfg_wdata[3:0];
      if (trig_we)  trig_sel <= trig_wdata;
    end
  end

  assign dir          = dir_e'(cfg_q[1:0]);
  assign rld          = rld_e'(cfg_q[3:2]);
  assign cfg_rd       = {{(CFG_W-4){1'b0}}, cfg_q};
  assign trig_enabled = |trig_sel;

  // R7
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_rd));
  // R10
  trig_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_we |=> (trig_sel == $past(trig_wdata)));
endmodule

// File: rtl/dda_boundary.sv
module dda_boundary
  import dda_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  rld_e rld,
  input  logic burst_end,
  input  logic block_end,
  input  logic txn_end,
  output logic start_evt,
  output logic reload_evt
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy;
  end

  assign start_evt  = busy && !busy_q;
  assign reload_evt = busy && busy_q && rld_match(rld, burst_end, block_end, txn_end);

  // R8
  start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !reload_evt);
  // R4
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rld == RLD_NONE) |-> !reload_evt);
endmodule

// File: rtl/dda_addr_reg.sv
module dda_addr_reg
  import dda_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  dir_e          dir,
  input  logic          beat_end,
  input  logic          start_evt,
  input  logic          reload_evt,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] addr,
  output logic          reload_flag
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] step_addr(logic [AW-1:0] a, dir_e d);
    case (d)
      DIR_INC: return a + ONE;
      DIR_DEC: return a - ONE;
      default: return a;
    endcase
  endfunction

  logic snap;
  logic move;

  assign snap = start_evt || reload_evt;
  assign move = busy && beat_end && !snap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr        <= '0;
      reload_flag <= 1'b0;
    end else begin
      if (snap)      addr <= start_addr;
      else if (move) addr <= step_addr(addr, dir);
      reload_flag <= reload_evt;
    end
  end

  // R5
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt && beat_end) |=> (addr == $past(start_addr)));
  // R8
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (addr == $past(start_addr)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(addr));
  // R3
  rsvd_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !snap && dir == DIR_RSVD) |=> $stable(addr));
  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move && dir == DIR_INC) |=> (addr == $past(addr) + ONE));
  // R11
  flag_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_flag |-> (addr == $past(start_addr)));
endmodule

// File: rtl/dma_dst_addr_gen.sv
module dma_dst_addr_gen
  import dda_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          trig_we,
  input  logic [7:0]    trig_wdata,
  input  logic          busy,
  input  logic [AW-1:0] start_addr,
  input  logic          beat_end,
  input  logic          burst_end,
  input  logic          block_end,
  input  logic          txn_end,
  output logic [AW-1:0] addr,
  output logic          reload_flag,
  output logic [7:0]    cfg_rd,
  output logic [7:0]    trig_sel,
  output logic          trig_enabled
);
  dir_e dir;
  rld_e rld;
  logic start_evt;
  logic reload_evt;

  dda_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata),
    .dir(dir), .rld(rld), .cfg_rd(cfg_rd),
    .trig_sel(trig_sel), .trig_enabled(trig_enabled)
  );

  dda_boundary u_bnd (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rld(rld),
    .burst_end(burst_end), .block_end(block_end), .txn_end(txn_end),
    .start_evt(start_evt), .reload_evt(reload_evt)
  );

  dda_addr_reg #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dir(dir),
    .beat_end(beat_end), .start_evt(start_evt), .reload_evt(reload_evt),
    .start_addr(start_addr), .addr(addr), .reload_flag(reload_flag)
  );
endmodule

// File: tb/dma_dst_addr_gen_tb.sv
module dma_dst_addr_gen_tb;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, trig_we = 1'b0;
  logic [7:0] cfg_wdata = '0, trig_wdata = '0;
  logic busy = 1'b0, beat_end = 1'b0, burst_end = 1'b0, block_end = 1'b0, txn_end = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] addr;
  logic reload_flag, trig_enabled;
  logic [7:0] cfg_rd, trig_sel;

  int total = 0, bad = 0;
  logic [AW-1:0] m_addr;
  logic [3:0] m_cfg;
  logic [7:0] m_trig;
  logic m_pbusy, m_flag;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  dma_dst_addr_gen #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .busy(busy),
    .start_addr(start_addr), .beat_end(beat_end), .burst_end(burst_end),
    .block_end(block_end), .txn_end(txn_end), .addr(addr),
    .reload_flag(reload_flag), .cfg_rd(cfg_rd), .trig_sel(trig_sel),
    .trig_enabled(trig_enabled)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive, predict, clock, compare
  task automatic tick(logic b, logic bt, logic bu, logic bl, logic tx, logic [AW-1:0] st,
                      logic cwe, logic [7:0] cwd, logic twe, logic [7:0] twd);
    logic hit;
    logic [AW-1:0] nxt;
    string tag;
    busy = b; beat_end = bt; burst_end = bu; block_end = bl; txn_end = tx;
    start_addr = st; cfg_we = cwe; cfg_wdata = cwd; trig_we = twe; trig_wdata = twd;
    hit = b && m_pbusy && ((m_cfg[3:2] == 2'd1 && bl) || (m_cfg[3:2] == 2'd2 && bu) ||
                           (m_cfg[3:2] == 2'd3 && tx));
    nxt = m_addr;
    if (!b) tag = "R9";
    else if (!m_pbusy) begin tag = "R8"; nxt = st; end
    else if (hit) begin tag = bt ? "R5" : "R4"; nxt = st; end
    else if (bt) begin
      tag = (m_cfg[1:0] == 2'd3) ? "R3" : "R2";
      if (m_cfg[1:0] == 2'd1) nxt = m_addr + 1'b1;
      else if (m_cfg[1:0] == 2'd2) nxt = m_addr - 1'b1;
    end else tag = "R6";
    @(posedge clk);
    m_addr = nxt;
    m_flag = hit;
    if (cwe && !b) m_cfg = cwd[3:0];
    if (twe) m_trig = twd;
    m_pbusy = b;
    #2;
    chk(tag, addr, m_addr);
    chk("R11", reload_flag, m_flag);
    chk("R7", cfg_rd, {4'h0, m_cfg});
    chk("R10", {trig_enabled, trig_sel}, {(m_trig != 0), m_trig});
  endtask

  task automatic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_addr = '0; m_cfg = '0; m_trig = '0; m_pbusy = 1'b0; m_flag = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    chk("R1", addr, 0);
    chk("R1", cfg_rd, 0);
    chk("R1", trig_sel, 0);
    chk("R1", trig_enabled, 0);
    chk("R1", reload_flag, 0);

    // R10 trigger select, idle and busy
    tick(0, 0, 0, 0, 0, 4'h0, 0, 8'h00, 1, 8'h25);
    tick(1, 0, 0, 0, 0, 4'h0, 0, 8'h00, 1, 8'h00);
    tick(1, 0, 0, 0, 0, 4'h0, 0, 8'h00, 1, 8'hFF);
    tick(0, 0, 0, 0, 0, 4'h0, 0, 8'h00, 1, 8'h00);

    // R2 wrap: increment from 15, decrement from 0
    tick(0, 0, 0, 0, 0, 4'h0, 1, 8'hF1, 0, 8'h00);
    tick(1, 1, 0, 0, 0, 4'hF, 0, 8'h00, 0, 8'h00);
    tick(1, 1, 0, 0, 0, 4'hF, 0, 8'h00, 0, 8'h00);
    chk("R2", addr, 0);
    tick(0, 0, 0, 0, 0, 4'h0, 1, 8'h02, 0, 8'h00);
    tick(1, 0, 0, 0, 0, 4'h0, 0, 8'h00, 0, 8'h00);
    tick(1, 1, 0, 0, 0, 4'h0, 0, 8'h00, 0, 8'h00);
    chk("R2", addr, 4'hF);

    // sweep every direction and reload pair with pseudo-random strobes
    for (int d = 0; d < 4; d++) begin
      for (int r = 0; r < 4; r++) begin
        tick(0, 0, 0, 0, 0, 4'h0, 1, 8'(r * 4 + d), 0, 8'h00);
        for (int k = 0; k < 80; k++) begin
          rnd();
          tick(lfsr[7:4] != 4'h0, lfsr[0], lfsr[1] & lfsr[2], lfsr[3] & lfsr[5],
               lfsr[6] & lfsr[8], lfsr[13:10],
               lfsr[14] & (lfsr[7:4] != 4'h0), {lfsr[15:12], lfsr[3:0]}, 0, 8'h00);
        end
      end
    end
    tick(0, 0, 0, 0, 0, 4'h0, 0, 8'h00, 0, 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule